// File: doc/BRIEF.md
# Matrix Key Report Filter

This block turns one scan frame of a key matrix into an ordered stream of key events. A frame carries up to eight entry slots, each with a live flag, a row number and a column number. The block walks the live slots in slot order. For each one it forms a scancode, reads the keycode for that scancode from an external combinational lookup port, and builds the list of keys held down in this frame. It keeps the list from the last frame it reported. From the two lists it emits release events for keycodes that are no longer held, then press events for every key held now, then a sync event that closes the frame.

Two options are sampled when a frame is accepted. The function-layer option hides the function key when it is held, and moves every other key of that frame to the upper half of the scancode space before a second lookup. The ghost filter option drops a whole frame whose key pattern could be produced by phantom contacts in the matrix. A dropped frame emits nothing and leaves the stored list as it was.

The frame input is taken only while the block is idle. Events leave through a valid/ready stream. A one-cycle done pulse marks the end of each frame, whether it was reported or dropped.

Top module: `key_event_reporter`

## Requirements
- R1: The scancode of a slot is its row times eight plus its column (row in bits 6:3, column in bits 2:0, bit 7 clear). It is driven on lut_scan during the lookup, and press events carry it on ev_scan with the looked-up keycode on ev_code.
- R2: With the function layer enabled, a slot whose keycode equals the FN_KEY parameter is neither counted nor reported. If such a slot is present, every other key of the frame has bit 7 of its scancode set and its keycode looked up again at that new scancode.
- R3: With the function layer disabled, the FN_KEY keycode is reported like any other key.
- R4: With the ghost filter enabled and three or more counted keys, a frame in which some pair shares a column and some pair shares a row produces no events, asserts done, and leaves the stored list unchanged.
- R5: A frame is reported normally when the ghost filter is off, or when fewer than three keys are counted, or when only rows or only columns are shared.
- R6: A release event (ev_kind 2'b00) is emitted for each stored keycode missing from the new frame's keycodes, in stored order, carrying its stored scancode. All releases of a frame come before any press.
- R7: A press event (ev_kind 2'b01) is emitted for every counted key in slot order, followed by one sync event (ev_kind 2'b10) with zero ev_code and ev_scan.
- R8: Once the sync event is accepted, the stored list and count become those of the frame just reported.
- R9: A frame with no counted keys releases every stored key and leaves the stored list empty.
- R10: frame_ready is high only when idle, and frame_valid is ignored otherwise. An event held while ev_ready is low keeps its fields. done pulses for one cycle after the sync handshake or after a dropped frame.
- R11: After reset, frame_ready is high, ev_valid and done are low, and the stored list is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_valid | input | 1 | Frame offered |
| frame_ready | output | 1 | Idle, frame accepted this cycle if offered |
| frame_live | input | MAX_KEYS | Per-slot live flag |
| frame_rows | input | MAX_KEYS*ROW_W | Per-slot row number, slot 0 in the low bits |
| frame_cols | input | MAX_KEYS*COL_W | Per-slot column number, slot 0 in the low bits |
| ghost_en | input | 1 | Ghost filter enable, sampled at accept |
| fn_layer_en | input | 1 | Function layer enable, sampled at accept |
| lut_scan | output | ROW_W+COL_W+1 | Scancode presented to the keycode lookup |
| lut_code | input | KEY_W | Keycode for lut_scan, same cycle |
| ev_valid | output | 1 | Event available |
| ev_ready | input | 1 | Event accepted when high with ev_valid |
| ev_kind | output | 2 | 00 release, 01 press, 10 sync |
| ev_code | output | KEY_W | Keycode of the event |
| ev_scan | output | ROW_W+COL_W+1 | Scancode of the event |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions take for granted that lut_code is a pure function of lut_scan within the cycle, and that the sink may drop ev_ready at any time without the block retracting an event. The stimulus answers lookups through a fixed arithmetic map in which one scancode returns FN_KEY. It throttles ev_ready with a pseudo-random pattern and offers a second frame while one is in progress. Rows and columns in the sweep are drawn from a small range, so that shared rows, shared columns, ghost patterns and function-key frames all occur often.

// File: rtl/krg_pkg.sv
// Shared types for the key report filter.
// Assumes: event kinds are fixed two-bit codes seen by the sink.
package krg_pkg;
    typedef enum logic [1:0] {
        EV_RELEASE = 2'b00,
        EV_PRESS   = 2'b01,
        EV_SYNC    = 2'b10
    } ev_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_SHIFT,
        ST_CHECK,
        ST_REL,
        ST_PRESS,
        ST_SYNC
    } krg_state_e;
endpackage

// File: rtl/krg_ghost_detect.sv
// Ghost pattern detector over the collected key list.
// Flags a frame of three or more keys where some pair shares a column
// and some (possibly other) pair shares a row.
// Assumes: only the first `count` entries of the list are meaningful.
module krg_ghost_detect #(
    parameter int N     = 8,
    parameter int ROW_W = 4,
    parameter int COL_W = 3,
    parameter int CNT_W = 4
) (
    input  logic [N*ROW_W-1:0] rows,
    input  logic [N*COL_W-1:0] cols,
    input  logic [CNT_W-1:0]   count,
    output logic               ghost
);
    logic [N-1:0] col_pair;
    logic [N-1:0] row_pair;

    for (genvar gi = 0; gi < N; gi++) begin : g_ent
        logic c_hit;
        logic r_hit;
        // Compare entry gi against every later live entry.
        always_comb begin
            c_hit = 1'b0;
            r_hit = 1'b0;
            for (int j = gi + 1; j < N; j++) begin
                if ((CNT_W'(j) < count) && (CNT_W'(gi) < count)) begin
                    if (cols[j*COL_W +: COL_W] == cols[gi*COL_W +: COL_W]) c_hit = 1'b1;
                    if (rows[j*ROW_W +: ROW_W] == rows[gi*ROW_W +: ROW_W]) r_hit = 1'b1;
                end
            end
        end
        assign col_pair[gi] = c_hit;
        assign row_pair[gi] = r_hit;
    end

    // A ghost needs at least three keys plus both kinds of sharing.
    assign ghost = (count >= CNT_W'(3)) && (|col_pair) && (|row_pair);
endmodule

// File: rtl/krg_key_match.sv
// Membership test: is a probe keycode among the first `count` list entries.
// Assumes: list entries at or beyond `count` hold stale data and are masked.
module krg_key_match #(
    parameter int N     = 8,
    parameter int KEY_W = 10,
    parameter int CNT_W = 4
) (
    input  logic [N*KEY_W-1:0] codes,
    input  logic [CNT_W-1:0]   count,
    input  logic [KEY_W-1:0]   probe,
    output logic               hit
);
    logic [N-1:0] eq;

    for (genvar gi = 0; gi < N; gi++) begin : g_cmp
        // One comparator per list slot, gated by liveness.
        assign eq[gi] = (CNT_W'(gi) < count) && (codes[gi*KEY_W +: KEY_W] == probe);
    end

    assign hit = |eq;
endmodule

// File: rtl/key_event_reporter.sv
// Key report filter top.
// Accepts one scan frame while idle, looks up each live slot serially,
// optionally applies the function layer and the ghost drop, then streams
// releases, presses and a sync event, and finally replaces the stored list.
// Assumes: lut_code is a combinational function of lut_scan; mode inputs
// are sampled when the frame is accepted.
module key_event_reporter #(
    parameter int          MAX_KEYS = 8,
    parameter int          ROW_W    = 4,
    parameter int          COL_W    = 3,
    parameter int          KEY_W    = 10,
    parameter int unsigned FN_KEY   = 464
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frame_valid,
    output logic                          frame_ready,
    input  logic [MAX_KEYS-1:0]           frame_live,
    input  logic [MAX_KEYS*ROW_W-1:0]     frame_rows,
    input  logic [MAX_KEYS*COL_W-1:0]     frame_cols,
    input  logic                          ghost_en,
    input  logic                          fn_layer_en,
    output logic [ROW_W+COL_W:0]          lut_scan,
    input  logic [KEY_W-1:0]              lut_code,
    output logic                          ev_valid,
    input  logic                          ev_ready,
    output logic [1:0]                    ev_kind,
    output logic [KEY_W-1:0]              ev_code,
    output logic [ROW_W+COL_W:0]          ev_scan,
    output logic                          done
);
    import krg_pkg::*;

    localparam int SCAN_W    = ROW_W + COL_W + 1;
    localparam int LAYER_BIT = ROW_W + COL_W;
    localparam int CNT_W     = $clog2(MAX_KEYS + 1);
    localparam int PTR_W     = (MAX_KEYS > 1) ? $clog2(MAX_KEYS) : 1;
    localparam logic [KEY_W-1:0] FN_CODE  = KEY_W'(FN_KEY);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_KEYS - 1);

    krg_state_e st;
    logic [CNT_W-1:0]  idx;
    logic [PTR_W-1:0]  ptr;
    logic [MAX_KEYS-1:0] in_live;
    logic [ROW_W-1:0]  in_row   [MAX_KEYS];
    logic [COL_W-1:0]  in_col   [MAX_KEYS];
    logic [SCAN_W-1:0] new_scan [MAX_KEYS];
    logic [KEY_W-1:0]  new_code [MAX_KEYS];
    logic [CNT_W-1:0]  new_num;
    logic [SCAN_W-1:0] old_scan [MAX_KEYS];
    logic [KEY_W-1:0]  old_code [MAX_KEYS];
    logic [CNT_W-1:0]  old_num;
    logic              fn_seen;
    logic              mode_ghost;
    logic              mode_fn;
    logic              done_q;

    logic [MAX_KEYS*KEY_W-1:0] new_code_flat;
    logic [MAX_KEYS*ROW_W-1:0] new_row_flat;
    logic [MAX_KEYS*COL_W-1:0] new_col_flat;
    logic ghost_hit;
    logic still_held;
    logic is_fn;
    logic rel_emit;
    logic press_emit;
    logic sync_emit;

    assign ptr = idx[PTR_W-1:0];

    // Flatten the collected list for the comparison submodules.
    for (genvar gi = 0; gi < MAX_KEYS; gi++) begin : g_flat
        assign new_code_flat[gi*KEY_W +: KEY_W] = new_code[gi];
        assign new_row_flat[gi*ROW_W +: ROW_W]  = new_scan[gi][LAYER_BIT-1:COL_W];
        assign new_col_flat[gi*COL_W +: COL_W]  = new_scan[gi][COL_W-1:0];
    end

    krg_ghost_detect #(
        .N(MAX_KEYS), .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)
    ) u_ghost (
        .rows  (new_row_flat),
        .cols  (new_col_flat),
        .count (new_num),
        .ghost (ghost_hit)
    );

    krg_key_match #(
        .N(MAX_KEYS), .KEY_W(KEY_W), .CNT_W(CNT_W)
    ) u_match (
        .codes (new_code_flat),
        .count (new_num),
        .probe (old_code[ptr]),
        .hit   (still_held)
    );

    // Lookup address: raw slot scancode while scanning, layer-shifted in the shift pass.
    always_comb begin
        if (st == ST_SHIFT) lut_scan = {1'b1, new_scan[ptr][LAYER_BIT-1:0]};
        else                lut_scan = {1'b0, in_row[ptr], in_col[ptr]};
    end

    // Function key seen on the lookup this cycle (only when the layer is on).
    assign is_fn = mode_fn && (lut_code == FN_CODE);

    // Which kind of event, if any, is offered this cycle.
    always_comb begin
        rel_emit   = (st == ST_REL) && (idx < old_num) && !still_held;
        press_emit = (st == ST_PRESS) && (idx < new_num);
        sync_emit  = (st == ST_SYNC);
    end

    // Output stream fields selected from the list being walked.
    always_comb begin
        ev_valid = rel_emit || press_emit || sync_emit;
        ev_kind  = EV_SYNC;
        ev_code  = '0;
        ev_scan  = '0;
        if (rel_emit) begin
            ev_kind = EV_RELEASE;
            ev_code = old_code[ptr];
            ev_scan = old_scan[ptr];
        end else if (press_emit) begin
            ev_kind = EV_PRESS;
            ev_code = new_code[ptr];
            ev_scan = new_scan[ptr];
        end
    end

    assign frame_ready = (st == ST_IDLE);
    assign done        = done_q;

    // Frame sequencer: accept, collect, shift, filter, report, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            idx        <= '0;
            in_live    <= '0;
            new_num    <= '0;
            old_num    <= '0;
            fn_seen    <= 1'b0;
            mode_ghost <= 1'b0;
            mode_fn    <= 1'b0;
            done_q     <= 1'b0;
            for (int i = 0; i < MAX_KEYS; i++) begin
                in_row[i]   <= '0;
                in_col[i]   <= '0;
                new_scan[i] <= '0;
                new_code[i] <= '0;
                old_scan[i] <= '0;
                old_code[i] <= '0;
            end
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (frame_valid) begin
                        in_live    <= frame_live;
                        for (int i = 0; i < MAX_KEYS; i++) begin
                            in_row[i] <= frame_rows[i*ROW_W +: ROW_W];
                            in_col[i] <= frame_cols[i*COL_W +: COL_W];
                        end
                        mode_ghost <= ghost_en;
                        mode_fn    <= fn_layer_en;
                        idx        <= '0;
                        new_num    <= '0;
                        fn_seen    <= 1'b0;
                        st         <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (in_live[ptr]) begin
                        if (is_fn) begin
                            fn_seen <= 1'b1;
                        end else begin
                            new_scan[new_num[PTR_W-1:0]] <= lut_scan;
                            new_code[new_num[PTR_W-1:0]] <= lut_code;
                            new_num <= new_num + 1'b1;
                        end
                    end
                    if (idx == LAST_IDX) begin
                        idx <= '0;
                        st  <= (fn_seen || (in_live[ptr] && is_fn)) ? ST_SHIFT : ST_CHECK;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (idx < new_num) begin
                        new_scan[ptr] <= lut_scan;
                        new_code[ptr] <= lut_code;
                        idx <= idx + 1'b1;
                    end else begin
                        idx <= '0;
                        st  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (mode_ghost && ghost_hit) begin
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end else begin
                        idx <= '0;
                        st  <= ST_REL;
                    end
                end
                ST_REL: begin
                    if (idx < old_num) begin
                        if (still_held || ev_ready) idx <= idx + 1'b1;
                    end else begin
                        idx <= '0;
                        st  <= ST_PRESS;
                    end
                end
                ST_PRESS: begin
                    if (idx < new_num) begin
                        if (ev_ready) idx <= idx + 1'b1;
                    end else begin
                        st <= ST_SYNC;
                    end
                end
                ST_SYNC: begin
                    if (ev_ready) begin
                        old_scan <= new_scan;
                        old_code <= new_code;
                        old_num  <= new_num;
                        done_q   <= 1'b1;
                        st       <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/key_event_reporter_checker.sv
// Protocol checker for the key report filter, bound to the top.
// Assumes: synchronous active-low reset; checks only port behaviour.
module key_event_reporter_checker #(
    parameter int KEY_W  = 10,
    parameter int SCAN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_ready,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic [1:0]        ev_kind,
    input logic [KEY_W-1:0]  ev_code,
    input logic [SCAN_W-1:0] ev_scan,
    input logic              done
);
    logic press_seen;

    // Track whether a press has been handed over in the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          press_seen <= 1'b0;
        else if (done)                                       press_seen <= 1'b0;
        else if (ev_valid && ev_ready && ev_kind == 2'b01)   press_seen <= 1'b1;
    end

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready |-> !ev_valid);

    a_r10_hold_event: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_kind) && $stable(ev_code) && $stable(ev_scan)));

    a_r10_done_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready && ev_kind == 2'b10) |=> done);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> frame_ready);

    a_r6_release_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready && ev_kind == 2'b00) |-> !press_seen);
endmodule

bind key_event_reporter key_event_reporter_checker #(
    .KEY_W  (KEY_W),
    .SCAN_W (ROW_W + COL_W + 1)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_ready (frame_ready),
    .ev_valid    (ev_valid),
    .ev_ready    (ev_ready),
    .ev_kind     (ev_kind),
    .ev_code     (ev_code),
    .ev_scan     (ev_scan),
    .done        (done)
);

// File: tb/key_event_reporter_bench.sv
`timescale 1ns/1ps
module key_event_reporter_bench;
    localparam int N = 8;
    localparam logic [9:0] FNK = 10'd464;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_valid = 1'b0;
    logic frame_ready;
    logic [7:0]  frame_live = '0;
    logic [31:0] frame_rows = '0;
    logic [23:0] frame_cols = '0;
    logic ghost_en = 1'b0;
    logic fn_layer_en = 1'b0;
    logic [7:0] lut_scan;
    logic [9:0] lut_code;
    logic ev_valid;
    logic ev_ready = 1'b0;
    logic [1:0] ev_kind;
    logic [9:0] ev_code;
    logic [7:0] ev_scan;
    logic done;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    key_event_reporter u_key_event_reporter (
        .clk(clk), .rst_n(rst_n),
        .frame_valid(frame_valid), .frame_ready(frame_ready),
        .frame_live(frame_live), .frame_rows(frame_rows), .frame_cols(frame_cols),
        .ghost_en(ghost_en), .fn_layer_en(fn_layer_en),
        .lut_scan(lut_scan), .lut_code(lut_code),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind),
        .ev_code(ev_code), .ev_scan(ev_scan), .done(done)
    );

    // Keycode map: scancode 7 (row 0, column 7) is the function key, others scan+16.
    function automatic logic [9:0] ref_lut(input logic [7:0] s);
        return (s == 8'd7) ? FNK : (10'(s) + 10'd16);
    endfunction
    assign lut_code = ref_lut(lut_scan);

    // Reference stored list and expected / observed event lists {kind,code,scan}.
    logic [7:0] m_scan [N];
    logic [9:0] m_code [N];
    int m_num = 0;
    logic [19:0] x_ev [32];
    logic [19:0] g_ev [32];
    int x_n;
    int g_n;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic build_expect(input logic [7:0] live, input logic [31:0] rows,
                                input logic [23:0] cols, input bit fn, input bit gh);
        logic [7:0] ns [N];
        logic [9:0] nc [N];
        int nn;
        bit fs;
        bit cc;
        bit rr;
        nn = 0; fs = 0; cc = 0; rr = 0; x_n = 0;
        for (int i = 0; i < N; i++) begin ns[i] = '0; nc[i] = '0; end
        for (int i = 0; i < N; i++) begin
            if (live[i]) begin
                logic [7:0] s;
                s = {1'b0, rows[i*4 +: 4], cols[i*3 +: 3]};
                if (fn && ref_lut(s) == FNK) fs = 1;
                else begin ns[nn] = s; nc[nn] = ref_lut(s); nn++; end
            end
        end
        if (fs) for (int i = 0; i < nn; i++) begin ns[i] = ns[i] | 8'h80; nc[i] = ref_lut(ns[i]); end
        for (int i = 0; i < nn; i++)
            for (int j = i + 1; j < nn; j++) begin
                if (ns[i][2:0] == ns[j][2:0]) cc = 1;
                if (ns[i][6:3] == ns[j][6:3]) rr = 1;
            end
        if (gh && nn >= 3 && cc && rr) return;
        for (int i = 0; i < m_num; i++) begin
            bit found;
            found = 0;
            for (int j = 0; j < nn; j++) if (nc[j] == m_code[i]) found = 1;
            if (!found) begin x_ev[x_n] = {2'b00, m_code[i], m_scan[i]}; x_n++; end
        end
        for (int j = 0; j < nn; j++) begin x_ev[x_n] = {2'b01, nc[j], ns[j]}; x_n++; end
        x_ev[x_n] = {2'b10, 10'd0, 8'd0}; x_n++;
        for (int i = 0; i < N; i++) begin m_scan[i] = ns[i]; m_code[i] = nc[i]; end
        m_num = nn;
    endtask

    // Offer a frame, collect its events until done, compare with the reference.
    task automatic run_frame(input logic [7:0] live, input logic [31:0] rows,
                             input logic [23:0] cols, input bit fn, input bit gh,
                             input bit throttle, input bit inject, input string tag);
        int cyc;
        bit fin;
        build_expect(live, rows, cols, fn, gh);
        @(negedge clk);
        while (!frame_ready) @(negedge clk);
        frame_valid = 1; frame_live = live; frame_rows = rows; frame_cols = cols;
        fn_layer_en = fn; ghost_en = gh;
        @(negedge clk);
        frame_valid = 0;
        if (inject) check(frame_ready == 1'b0, "R10 busy after accept", frame_ready, 0);
        g_n = 0; cyc = 0; fin = 0;
        while (!fin && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 2) begin
                frame_valid = 1; frame_live = 8'hFF; frame_rows = 32'h7654_3210;
                frame_cols = 24'hFAC688; fn_layer_en = ~fn; ghost_en = ~gh;
            end
            if (inject && cyc == 4) frame_valid = 0;
            if (done) fin = 1;
            else begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                ev_ready = throttle ? (lfsr[0] | lfsr[5]) : 1'b1;
                if (ev_valid && ev_ready && g_n < 32) begin
                    g_ev[g_n] = {ev_kind, ev_code, ev_scan};
                    g_n++;
                end
            end
        end
        ev_ready = 0;
        check(fin, {tag, " done seen"}, fin, 1);
        check(g_n == x_n, {tag, " event count"}, g_n, x_n);
        for (int k = 0; k < x_n && k < g_n; k++)
            check(g_ev[k] == x_ev[k], {tag, " event"}, g_ev[k], x_ev[k]);
    endtask

    function automatic logic [31:0] rows3(input int a, input int b, input int c);
        return {20'd0, 4'(c), 4'(b), 4'(a)};
    endfunction
    function automatic logic [23:0] cols3(input int a, input int b, input int c);
        return {15'd0, 3'(c), 3'(b), 3'(a)};
    endfunction

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        bit found;
        for (int i = 0; i < N; i++) begin m_scan[i] = '0; m_code[i] = '0; end
        repeat (3) @(negedge clk);
        check(frame_ready == 1'b1, "R11 frame_ready after reset", frame_ready, 1);
        check(ev_valid == 1'b0, "R11 ev_valid after reset", ev_valid, 0);
        check(done == 1'b0, "R11 done after reset", done, 0);
        rst_n = 1;
        @(negedge clk);
        check(frame_ready == 1'b1 && ev_valid == 1'b0, "R11 idle after release", {frame_ready, ev_valid}, 2'b10);

        // R11 stored list empty: an empty first frame gives only a sync.
        run_frame(8'h00, 32'd0, 24'd0, 0, 0, 0, 0, "R11 empty first");
        check(g_n == 1 && g_ev[0][19:18] == 2'b10, "R11 only sync", g_n, 1);

        // R1 R7: two keys, row 2 col 1 (scan 0x11) and row 5 col 6 (scan 0x2E).
        run_frame(8'h03, rows3(2, 5, 0), cols3(1, 6, 0), 0, 0, 0, 0, "R7 two keys");
        check(g_ev[0][7:0] == 8'h11, "R1 scancode row2 col1", g_ev[0][7:0], 8'h11);
        check(g_ev[0][17:8] == 10'h021, "R1 looked-up keycode", g_ev[0][17:8], 10'h021);
        check(g_ev[2][19:18] == 2'b10 && g_ev[2][17:0] == 18'd0, "R7 closing sync", g_ev[2], 20'h80000);

        // R6: one key kept, one dropped, one new; release must come first.
        run_frame(8'h03, rows3(5, 1, 0), cols3(6, 0, 0), 0, 0, 0, 0, "R6 diff");
        check(g_ev[0] == {2'b00, 10'h021, 8'h11}, "R6 release first", g_ev[0], {2'b00, 10'h021, 8'h11});

        // R3: layer off, function key reported plainly.
        run_frame(8'h03, rows3(0, 3, 0), cols3(7, 2, 0), 0, 0, 1, 0, "R3 fn plain");
        found = 0;
        for (int k = 0; k < g_n; k++) if (g_ev[k] == {2'b01, FNK, 8'h07}) found = 1;
        check(found, "R3 fn key pressed", found, 1);

        // R2: layer on, function key hidden, other key shifted to 0x9A.
        run_frame(8'h03, rows3(0, 3, 0), cols3(7, 2, 0), 1, 0, 1, 0, "R2 fn layer");
        found = 0;
        for (int k = 0; k < g_n; k++) if (g_ev[k][19:18] == 2'b01 && g_ev[k][17:8] == FNK) found = 1;
        check(!found, "R2 fn press hidden", found, 0);
        found = 0;
        for (int k = 0; k < g_n; k++) if (g_ev[k] == {2'b01, 10'h0AA, 8'h9A}) found = 1;
        check(found, "R2 shifted press", found, 1);

        // R4: ghost pattern dropped, then state shown unchanged by an empty frame.
        run_frame(8'h07, rows3(1, 1, 2), cols3(1, 2, 1), 0, 1, 1, 0, "R4 ghost drop");
        check(g_n == 0, "R4 no events", g_n, 0);
        run_frame(8'h00, 32'd0, 24'd0, 0, 0, 0, 0, "R4 R9 release stored");
        check(g_n == 2 && g_ev[0] == {2'b00, 10'h0AA, 8'h9A}, "R4 stored list kept", g_ev[0], {2'b00, 10'h0AA, 8'h9A});
        run_frame(8'h00, 32'd0, 24'd0, 0, 0, 0, 0, "R9 cleared");
        check(g_n == 1, "R9 nothing left", g_n, 1);

        // R5: same ghost pattern with filter off; rows-only sharing with filter on.
        run_frame(8'h07, rows3(1, 1, 2), cols3(1, 2, 1), 0, 0, 0, 0, "R5 filter off");
        check(g_n == 4, "R5 reported", g_n, 4);
        run_frame(8'h07, rows3(1, 1, 1), cols3(1, 2, 3), 0, 1, 1, 0, "R5 rows only");
        run_frame(8'h03, rows3(4, 4, 0), cols3(4, 5, 0), 0, 1, 0, 0, "R5 two keys");

        // R10: a second frame offered while busy is ignored, under backpressure.
        run_frame(8'h05, rows3(6, 0, 7), cols3(3, 0, 0), 0, 0, 1, 1, "R10 ignore busy");
        @(negedge clk);
        check(done == 1'b0, "R10 done single cycle", done, 0);

        // R8 sweep over small rows and columns with frequent function keys.
        for (int f = 0; f < 400; f++) begin
            logic [7:0] lv;
            logic [31:0] rw;
            logic [23:0] cl;
            lv = 8'($urandom_range(0, 255));
            if (f % 4 == 0) lv = lv & 8'h0F;
            rw = '0; cl = '0;
            for (int i = 0; i < N; i++) begin
                if ($urandom_range(0, 5) == 0) begin
                    rw[i*4 +: 4] = 4'd0; cl[i*3 +: 3] = 3'd7;
                end else begin
                    rw[i*4 +: 4] = 4'($urandom_range(0, 3));
                    cl[i*3 +: 3] = 3'($urandom_range(0, 3));
                end
            end
            run_frame(lv, rw, cl, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      1'(f % 2), 0, "R8 sweep");
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule